// File: doc/BRIEF.md
# Fixed-Point Vector MAC Slice

This block is one SIMD slice of a vector arithmetic unit. Each cycle it can accept one operation over sixteen lanes of 16-bit signed fixed-point data. It multiplies two operand vectors lane by lane. The products either replace the 32-bit accumulators or are added into them. A third operation narrows a 32-bit accumulator vector back to 16-bit lanes, using a right shift, a rounding mode and saturation. Four such slices side by side form one vector unit with 64 multiply-accumulates per cycle.

The operand precision can be gated at runtime. Low-order operand bits are forced to zero before the multiplier, so the effective multiplier width drops and toggling is reduced. The shift amount, the rounding mode and the precision live in configuration registers. The datapath is a three-stage pipeline that takes a new operation every cycle. Each operation travels with the configuration that was valid when it was issued.

Top module: `vmac_slice`

## Requirements
- R1: After reset `out_valid` and `sat_sticky` are 0, and the configuration is shift 0, rounding truncate and full 16-bit precision.
- R2: Opcode 0 (multiply) gives, in each lane i, `acc_out[32i+31:32i]` equal to the signed product of the gated `opa[16i+15:16i]` and `opb[16i+15:16i]`, sign-extended to 32 bits.
- R3: Opcode 1 (multiply-accumulate) gives, in each lane, `acc_in` lane plus the signed gated product, wrapping modulo 2^32.
- R4: Precision code 0 keeps all 16 operand bits, code 1 keeps the top 12 bits, and codes 2 and 3 keep the top 8 bits. The dropped low bits of both operands are zero before the multiply.
- R5: Opcode 2 (narrow) shifts each `acc_in` lane arithmetically right by the configured shift (0 to 15) and rounds. Rounding code 0 and code 3 truncate toward minus infinity, code 1 rounds half up, and code 2 rounds half to even. Opcodes 2 and 3 pass `acc_in` to `acc_out` unchanged, and `narrow_out` is zero for every opcode other than 2.
- R6: A narrowed value above 32767 or below -32768 is clamped to that limit.
- R7: `out_valid` and the results of an operation appear exactly three rising edges after the edge that captured it with `in_valid` high. One operation is accepted per cycle.
- R8: `sat_sticky` rises one cycle after a valid narrow result that clamped in any lane. It stays high until `sat_clr` is sampled high, and a new clamp in the same cycle as `sat_clr` keeps it high.
- R9: A configuration write with `cfg_we` affects operations captured on later edges. Operations captured on the same edge or earlier, including those in flight, keep the configuration they were issued with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the configuration registers |
| cfg_shift | input | 4 | Right-shift amount for narrowing |
| cfg_rnd | input | 2 | Rounding mode code |
| cfg_prec | input | 2 | Operand precision code |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 2 | Opcode: 0 multiply, 1 multiply-accumulate, 2 narrow, 3 pass |
| opa | input | 256 | Operand vector A, 16 lanes of 16 bits |
| opb | input | 256 | Operand vector B, 16 lanes of 16 bits |
| acc_in | input | 512 | Accumulator vector in, 16 lanes of 32 bits |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| out_valid | output | 1 | Results on the outputs are valid |
| acc_out | output | 512 | Accumulator vector result |
| narrow_out | output | 256 | Narrowed 16-bit result vector |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Two pairs of events can land in one cycle. The first pair is a clamped narrow result reaching the output while `sat_clr` is high. The second is a configuration write on the edge where an operation is issued, while earlier operations are still in the pipeline. Random streams with frequent config writes and clear pulses provoke both, and directed sequences place a clear exactly on a clamping result. A bench model decides the outcome: the flag stays set, and each operation uses the configuration held in the register when it was captured.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    typedef enum logic [1:0] {
        OP_MUL    = 2'd0,
        OP_MAC    = 2'd1,
        OP_NARROW = 2'd2,
        OP_PASS   = 2'd3
    } vop_e;

    typedef enum logic [1:0] {
        RND_TRUNC     = 2'd0,
        RND_HALF_UP   = 2'd1,
        RND_HALF_EVEN = 2'd2,
        RND_TRUNC_ALT = 2'd3
    } rnd_e;

    typedef enum logic [1:0] {
        PREC_FULL   = 2'd0,
        PREC_3Q     = 2'd1,
        PREC_HALF   = 2'd2,
        PREC_HALF_B = 2'd3
    } prec_e;

endpackage

// File: rtl/vmac_cfg.sv
module vmac_cfg
    import vmac_pkg::*;
#(
    parameter int SHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [SHW-1:0] shift_d,
    input  logic [1:0]     rnd_d,
    input  logic [1:0]     prec_d,
    output logic [SHW-1:0] shift_q,
    output rnd_e           rnd_q,
    output prec_e          prec_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            rnd_q   <= RND_TRUNC;
            prec_q  <= PREC_FULL;
        end else if (we) begin
            shift_q <= shift_d;
            rnd_q   <= rnd_e'(rnd_d);
            prec_q  <= prec_e'(prec_d);
        end
    end

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
    import vmac_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 2 * OPW,
    parameter int SHW  = $clog2(OPW)
) (
    input  logic                   clk,
    input  logic                   en1,
    input  logic                   en2,
    input  logic                   en3,
    input  vop_e                   op,
    input  logic signed [OPW-1:0]  a,
    input  logic signed [OPW-1:0]  b,
    input  logic signed [ACCW-1:0] acc,
    input  logic [SHW-1:0]         shift,
    input  rnd_e                   rnd,
    input  prec_e                  prec,
    output logic signed [ACCW-1:0] acc_res,
    output logic [OPW-1:0]         nar_res,
    output logic                   sat
);

    localparam int KEEP3Q = (OPW * 3) / 4;
    localparam int KEEPH  = OPW / 2;
    localparam logic [OPW-1:0] MASK_3Q = {{KEEP3Q{1'b1}}, {(OPW-KEEP3Q){1'b0}}};
    localparam logic [OPW-1:0] MASK_H  = {{KEEPH{1'b1}}, {(OPW-KEEPH){1'b0}}};
    localparam logic signed [ACCW:0] MAXV = $signed({{(ACCW-OPW+2){1'b0}}, {(OPW-1){1'b1}}});
    localparam logic signed [ACCW:0] MINV = $signed({{(ACCW-OPW+2){1'b1}}, {(OPW-1){1'b0}}});

    // stage 1: gated operands and carried control
    logic [OPW-1:0]         gmask;
    logic signed [OPW-1:0]  s1_a, s1_b;
    logic signed [ACCW-1:0] s1_acc;
    vop_e                   s1_op;
    logic [SHW-1:0]         s1_shift;
    rnd_e                   s1_rnd;

    always_comb begin
        unique case (prec)
            PREC_FULL: gmask = '1;
            PREC_3Q:   gmask = MASK_3Q;
            default:   gmask = MASK_H;
        endcase
    end

    always_ff @(posedge clk) begin
        if (en1) begin
            s1_a     <= a & gmask;
            s1_b     <= b & gmask;
            s1_acc   <= acc;
            s1_op    <= op;
            s1_shift <= shift;
            s1_rnd   <= rnd;
        end
    end

    // stage 2: product
    logic signed [ACCW-1:0] s2_prod, s2_acc;
    vop_e                   s2_op;
    logic [SHW-1:0]         s2_shift;
    rnd_e                   s2_rnd;

    always_ff @(posedge clk) begin
        if (en2) begin
            s2_prod  <= s1_a * s1_b;
            s2_acc   <= s1_acc;
            s2_op    <= s1_op;
            s2_shift <= s1_shift;
            s2_rnd   <= s1_rnd;
        end
    end

    // stage 3: accumulate or narrow
    logic signed [ACCW:0] ext, shr, rounded;
    logic [ACCW:0]        half_mask;
    logic                 guard, below, inc, hi, lo;
    logic [OPW-1:0]       nar_c;
    logic signed [ACCW-1:0] acc_c;

    always_comb begin
        ext       = {s2_acc[ACCW-1], s2_acc};
        shr       = ext >>> s2_shift;
        half_mask = (s2_shift == '0) ? '0 : ({{ACCW{1'b0}}, 1'b1} << (s2_shift - 1'b1));
        guard     = |(ext & half_mask);
        below     = (s2_shift != '0) && (|(ext & (half_mask - 1'b1)));
        unique case (s2_rnd)
            RND_HALF_UP:   inc = guard;
            RND_HALF_EVEN: inc = guard & (below | shr[0]);
            default:       inc = 1'b0;
        endcase
        rounded = shr + $signed({{ACCW{1'b0}}, inc});
        hi      = rounded > MAXV;
        lo      = rounded < MINV;
        if (hi)      nar_c = MAXV[OPW-1:0];
        else if (lo) nar_c = MINV[OPW-1:0];
        else         nar_c = rounded[OPW-1:0];

        unique case (s2_op)
            OP_MUL:  acc_c = s2_prod;
            OP_MAC:  acc_c = s2_acc + s2_prod;
            default: acc_c = s2_acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (en3) begin
            acc_res <= acc_c;
            nar_res <= (s2_op == OP_NARROW) ? nar_c : '0;
            sat     <= (s2_op == OP_NARROW) && (hi || lo);
        end
    end

endmodule

// File: rtl/vmac_sat.sv
module vmac_sat (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic sticky
);

    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= 1'b0;
        else        sticky <= set | (sticky & ~clr);
    end

endmodule

// File: rtl/vmac_slice.sv
module vmac_slice
    import vmac_pkg::*;
#(
    parameter int LANES = 16,
    parameter int OPW   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [$clog2(OPW)-1:0]    cfg_shift,
    input  logic [1:0]                cfg_rnd,
    input  logic [1:0]                cfg_prec,
    input  logic                      in_valid,
    input  logic [1:0]                in_op,
    input  logic [LANES*OPW-1:0]      opa,
    input  logic [LANES*OPW-1:0]      opb,
    input  logic [LANES*OPW*2-1:0]    acc_in,
    input  logic                      sat_clr,
    output logic                      out_valid,
    output logic [LANES*OPW*2-1:0]    acc_out,
    output logic [LANES*OPW-1:0]      narrow_out,
    output logic                      sat_sticky
);

    localparam int ACCW = 2 * OPW;
    localparam int SHW  = $clog2(OPW);

    logic [SHW-1:0] cfg_shift_q;
    rnd_e           cfg_rnd_q;
    prec_e          cfg_prec_q;

    vmac_cfg #(.SHW(SHW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .shift_d (cfg_shift),
        .rnd_d   (cfg_rnd),
        .prec_d  (cfg_prec),
        .shift_q (cfg_shift_q),
        .rnd_q   (cfg_rnd_q),
        .prec_q  (cfg_prec_q)
    );

    // valid pipeline, three stages
    logic v1, v2, v3;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end
    assign out_valid = v3;

    logic [LANES-1:0] lane_sat;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vmac_lane #(.OPW(OPW), .ACCW(ACCW), .SHW(SHW)) u_lane (
            .clk     (clk),
            .en1     (in_valid),
            .en2     (v1),
            .en3     (v2),
            .op      (vop_e'(in_op)),
            .a       (opa[i*OPW +: OPW]),
            .b       (opb[i*OPW +: OPW]),
            .acc     (acc_in[i*ACCW +: ACCW]),
            .shift   (cfg_shift_q),
            .rnd     (cfg_rnd_q),
            .prec    (cfg_prec_q),
            .acc_res (acc_out[i*ACCW +: ACCW]),
            .nar_res (narrow_out[i*OPW +: OPW]),
            .sat     (lane_sat[i])
        );
    end

    vmac_sat u_sat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (v3 & (|lane_sat)),
        .clr    (sat_clr),
        .sticky (sat_sticky)
    );

endmodule

// File: rtl/vmac_slice_chk.sv
module vmac_slice_chk #(
    parameter int OPW = 16,
    parameter int SHW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [1:0]           in_op,
    input logic                 cfg_we,
    input logic                 sat_clr,
    input logic                 out_valid,
    input logic [16*OPW-1:0]    narrow_out,
    input logic                 sat_sticky,
    input logic [SHW-1:0]       cfg_shift_q,
    input logic [1:0]           cfg_rnd_q,
    input logic [1:0]           cfg_prec_q
);

    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)           age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R7
    latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R5
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_valid && ($past(in_op, 3) != 2'd2)) |-> (narrow_out == '0));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_sticky && !sat_clr) |=> sat_sticky);

    // R8
    sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_sticky) |-> $past(out_valid));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable({cfg_shift_q, cfg_rnd_q, cfg_prec_q}));

endmodule

bind vmac_slice vmac_slice_chk #(.OPW(OPW), .SHW($clog2(OPW))) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .cfg_we      (cfg_we),
    .sat_clr     (sat_clr),
    .out_valid   (out_valid),
    .narrow_out  (narrow_out),
    .sat_sticky  (sat_sticky),
    .cfg_shift_q (cfg_shift_q),
    .cfg_rnd_q   (cfg_rnd_q),
    .cfg_prec_q  (cfg_prec_q)
);

// File: tb/test_vmac_slice.sv
module test_vmac_slice;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_shift = '0;
    logic [1:0]   cfg_rnd = '0;
    logic [1:0]   cfg_prec = '0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = '0;
    logic [255:0] opa = '0;
    logic [255:0] opb = '0;
    logic [511:0] acc_in = '0;
    logic         sat_clr = 1'b0;
    logic         out_valid;
    logic [511:0] acc_out;
    logic [255:0] narrow_out;
    logic         sat_sticky;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmac_slice i_vmac_slice (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_shift(cfg_shift),
        .cfg_rnd(cfg_rnd), .cfg_prec(cfg_prec), .in_valid(in_valid), .in_op(in_op),
        .opa(opa), .opb(opb), .acc_in(acc_in), .sat_clr(sat_clr),
        .out_valid(out_valid), .acc_out(acc_out), .narrow_out(narrow_out),
        .sat_sticky(sat_sticky)
    );

    int checks = 0;
    int errors = 0;
    int tcount = 0;
    bit finished = 1'b0;

    // model state
    logic [3:0] m_shift = '0;
    logic [1:0] m_rnd = '0;
    logic [1:0] m_prec = '0;
    bit         m_sticky = 1'b0;
    bit           e_v   [4];
    logic [1:0]   e_op  [4];
    logic [511:0] e_acc [4];
    logic [255:0] e_nar [4];
    bit           e_sat [4];

    function automatic logic [15:0] gate(input logic [15:0] x, input logic [1:0] p);
        if (p == 2'd0)      return x;
        else if (p == 2'd1) return {x[15:4], 4'h0};
        else                return {x[15:8], 8'h00};
    endfunction

    function automatic logic [16:0] bnar(input logic [31:0] v, input int s, input int r);
        longint q, rem, half, res;
        bit sat;
        q    = longint'($signed(v)) >>> s;
        rem  = longint'($signed(v)) - (q <<< s);
        half = (s == 0) ? 0 : (longint'(1) <<< (s - 1));
        res  = q;
        if (s != 0) begin
            if (r == 1 && rem >= half) res = q + 1;
            else if (r == 2 && (rem > half || (rem == half && q[0]))) res = q + 1;
        end
        sat = 1'b0;
        if (res > 32767)       begin res = 32767;  sat = 1'b1; end
        else if (res < -32768) begin res = -32768; sat = 1'b1; end
        return {sat, res[15:0]};
    endfunction

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R5";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [511:0] got, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // one cycle: check outputs, drive a new operation, advance
    task automatic step(input bit v, input logic [1:0] op, input logic [255:0] a,
                        input logic [255:0] b, input logic [511:0] acc, input bit we,
                        input logic [3:0] sh, input logic [1:0] rn, input logic [1:0] pr,
                        input bit clr);
        int cs, is;
        bit any_sat;
        cs = (tcount + 1) % 4;
        is = tcount % 4;
        if (tcount >= 3 && e_v[cs]) begin
            chk(out_valid == 1'b1, "R7", "out_valid", 512'(out_valid), 512'(1));
            chk(acc_out == e_acc[cs], tag_of(e_op[cs]), "acc_out", acc_out, e_acc[cs]);
            chk(narrow_out == e_nar[cs], (e_sat[cs] ? "R6" : "R5"), "narrow_out",
                512'(narrow_out), 512'(e_nar[cs]));
        end else begin
            chk(out_valid == 1'b0, "R7", "out_valid idle", 512'(out_valid), 512'(0));
        end
        chk(sat_sticky == m_sticky, "R8", "sat_sticky", 512'(sat_sticky), 512'(m_sticky));
        m_sticky = (m_sticky && !clr) || (tcount >= 3 && e_v[cs] && e_sat[cs]);

        in_valid = v; in_op = op; opa = a; opb = b; acc_in = acc;
        cfg_we = we; cfg_shift = sh; cfg_rnd = rn; cfg_prec = pr; sat_clr = clr;

        e_v[is] = v;
        e_op[is] = op;
        any_sat = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [15:0] ga, gb;
            logic [31:0] prod, la;
            logic [16:0] n;
            ga   = gate(a[i*16 +: 16], m_prec);
            gb   = gate(b[i*16 +: 16], m_prec);
            prod = 32'(longint'($signed(ga)) * longint'($signed(gb)));
            la   = acc[i*32 +: 32];
            n    = bnar(la, int'(m_shift), int'(m_rnd));
            case (op)
                2'd0: e_acc[is][i*32 +: 32] = prod;
                2'd1: e_acc[is][i*32 +: 32] = la + prod;
                default: e_acc[is][i*32 +: 32] = la;
            endcase
            e_nar[is][i*16 +: 16] = (op == 2'd2) ? n[15:0] : 16'h0;
            if (op == 2'd2 && n[16]) any_sat = 1'b1;
        end
        e_sat[is] = any_sat;
        if (we) begin m_shift = sh; m_rnd = rn; m_prec = pr; end

        @(posedge clk);
        @(negedge clk);
        tcount++;
    endtask

    task automatic idle(input int n, input bit clr);
        for (int k = 0; k < n; k++)
            step(1'b0, 2'd0, '0, '0, '0, 1'b0, '0, '0, '0, clr);
    endtask

    function automatic logic [15:0] rv16(input int mode);
        case (mode)
            0: return 16'h7FFF;
            1: return 16'h8000;
            2: return 16'($urandom_range(0, 15));
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [31:0] rv32(input int mode);
        case (mode)
            0: return 32'h7FFF_FFFF;
            1: return 32'h8000_0000;
            2: return 32'($signed(16'($urandom)));
            3: return {{12{1'b0}}, 20'($urandom)};
            default: return 32'($urandom);
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [255:0] a, b;
        logic [511:0] acc;
        for (int k = 0; k < 4; k++) begin e_v[k] = 1'b0; e_sat[k] = 1'b0; e_op[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 512'(out_valid), 512'(0));
        chk(sat_sticky == 1'b0, "R1", "sat_sticky after reset", 512'(sat_sticky), 512'(0));

        // R1 default config: full precision multiply, shift 0 truncating narrow
        for (int i = 0; i < 16; i++) begin
            a[i*16 +: 16] = 16'h1235 + 16'(i);
            b[i*16 +: 16] = 16'hF00F - 16'(i * 3);
            acc[i*32 +: 32] = 32'(i * 1000) - 32'd7000;
        end
        step(1'b1, 2'd0, a, b, acc, 1'b0, '0, '0, '0, 1'b0);
        step(1'b1, 2'd2, a, b, acc, 1'b0, '0, '0, '0, 1'b0);
        step(1'b1, 2'd1, a, b, acc, 1'b0, '0, '0, '0, 1'b0);
        step(1'b1, 2'd3, a, b, acc, 1'b0, '0, '0, '0, 1'b0);
        idle(3, 1'b0);

        // R4: precision 8 then 12, low bits set in operands
        step(1'b0, 2'd0, '0, '0, '0, 1'b1, 4'd0, 2'd0, 2'd2, 1'b0);
        step(1'b1, 2'd0, a, b, acc, 1'b1, 4'd0, 2'd0, 2'd1, 1'b0);
        step(1'b1, 2'd1, a, b, acc, 1'b1, 4'd0, 2'd0, 2'd3, 1'b0);
        step(1'b1, 2'd0, a, b, acc, 1'b1, 4'd0, 2'd0, 2'd0, 1'b0);
        idle(3, 1'b0);

        // R5: tie cases at shift 4 under each rounding mode
        for (int i = 0; i < 16; i++) begin
            case (i % 8)
                0: acc[i*32 +: 32] = 32'd8;
                1: acc[i*32 +: 32] = 32'd24;
                2: acc[i*32 +: 32] = -32'sd8;
                3: acc[i*32 +: 32] = -32'sd24;
                4: acc[i*32 +: 32] = 32'd9;
                5: acc[i*32 +: 32] = 32'd7;
                6: acc[i*32 +: 32] = -32'sd9;
                default: acc[i*32 +: 32] = 32'd40;
            endcase
        end
        for (int r = 0; r < 4; r++) begin
            step(1'b0, 2'd0, '0, '0, '0, 1'b1, 4'd4, 2'(r), 2'd0, 1'b0);
            step(1'b1, 2'd2, '0, '0, acc, 1'b0, '0, '0, '0, 1'b0);
        end
        idle(3, 1'b0);

        // R6 and R8: clamp high and low, clear arriving with a new clamp
        for (int i = 0; i < 16; i++)
            acc[i*32 +: 32] = (i % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        step(1'b0, 2'd0, '0, '0, '0, 1'b1, 4'd0, 2'd1, 2'd0, 1'b0);
        step(1'b1, 2'd2, '0, '0, acc, 1'b0, '0, '0, '0, 1'b0);
        step(1'b1, 2'd2, '0, '0, acc, 1'b0, '0, '0, '0, 1'b0);
        idle(2, 1'b0);
        idle(1, 1'b1);  // clear while second clamping result is at the output
        idle(1, 1'b1);  // plain clear
        idle(2, 1'b0);

        // R9: config write while narrows are in flight and on issue edge
        for (int i = 0; i < 16; i++) acc[i*32 +: 32] = 32'(i * 4099 + 77);
        step(1'b1, 2'd2, '0, '0, acc, 1'b1, 4'd3, 2'd2, 2'd0, 1'b0);
        step(1'b1, 2'd2, '0, '0, acc, 1'b1, 4'd0, 2'd0, 2'd0, 1'b0);
        step(1'b1, 2'd2, '0, '0, acc, 1'b1, 4'd7, 2'd1, 2'd2, 1'b0);
        step(1'b1, 2'd2, '0, '0, acc, 1'b0, '0, '0, '0, 1'b0);
        idle(3, 1'b0);

        // constrained random stream
        void'($urandom(32'd1357));
        for (int n = 0; n < 1500; n++) begin
            int am, bm, cm;
            am = int'($urandom_range(0, 6));
            bm = int'($urandom_range(0, 6));
            cm = int'($urandom_range(0, 7));
            for (int i = 0; i < 16; i++) begin
                a[i*16 +: 16] = rv16(am > 3 ? 3 : am);
                b[i*16 +: 16] = rv16(bm > 3 ? 3 : bm);
                acc[i*32 +: 32] = rv32(cm > 4 ? int'($urandom_range(0, 4)) : cm);
            end
            step($urandom_range(0, 9) != 0, 2'($urandom), a, b, acc,
                 $urandom_range(0, 7) == 0, 4'($urandom), 2'($urandom), 2'($urandom),
                 $urandom_range(0, 11) == 0);
        end
        idle(4, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule